// File: doc/BRIEF.md
# Dispatch Admission Controller

This block sits between a queue of decoded instructions and the out-of-order back end. Each cycle it looks at the oldest few queue slots and admits, in program order, as many instructions as the dispatch width and the free resources allow. Each instruction states how many micro-ops it has, how many destination registers need a new physical register, which scheduler it goes to, and whether it is a load, a store or an instruction that must be dispatched alone. The controller keeps credit counters for reorder-buffer entries, physical registers, the slots of each scheduler queue, and load and store queue slots. Consumers return credits through return ports when instructions retire, issue or finish their memory access.

If a valid instruction inside the width cannot be admitted, the cycle is a stall cycle. The controller puts it under exactly one of six reasons and counts it. A second set of counters records how many cycles admitted exactly N instructions, for each N from zero up to the largest width.

The controller is a small state machine. Reset enters `ST_LOAD`. There the configuration is sampled and every credit counter is filled to its capacity, and nothing is admitted. The `LOAD_DONE` transition moves the machine to `ST_RUN` after that one cycle. `ST_RUN` admits instructions and counts statistics, and it stays there (`RUN_HOLD`) until the next reset.

Top module: `dac_dispatch_ctrl`

## Requirements
- R1: During the single `ST_LOAD` cycle after reset, `ready` is 0, no instruction is admitted, no stall is flagged, and all statistics counters read zero. From the next cycle on, `ready` is 1.
- R2: The admitted instructions are always a contiguous run starting at slot 0. The first invalid slot or blocked instruction ends the group. A group that is cut short only by the width limit or by an invalid slot is not a stall.
- R3: The effective width is sampled in `ST_LOAD`. A `cfg_width` of 0 selects the default width of 2. A value above the maximum width of 4 is clamped to 4.
- R4: An instruction needs as many free reorder-buffer entries as its micro-op count. The buffer holds 8 entries and is refilled by `ret_rob`.
- R5: An instruction needs as many free physical registers as its destination count, out of `cfg_prf_limit`. Registers come back only through `ret_regs`, the retire return. A limit of 0 means unlimited, and the register check then always passes.
- R6: Each admitted instruction takes one slot of the scheduler named by its target ID. Each scheduler has 4 slots, and a scheduler's slot comes back when its `sched_ret` bit is 1.
- R7: A load takes one load-queue slot and a store takes one store-queue slot. A configured size of 0 selects the default size of 4 for that queue.
- R8: An instruction flagged solo is admitted only in slot 0, and no other instruction joins its group. A blocked solo, or any instruction after an admitted solo, is a group-restriction stall.
- R9: A stall takes the reason of the first failing check, tested in this order: registers (code 0), retire tokens/reorder buffer (1), scheduler (2), load queue (3), store queue (4), group restriction (5). The code is shown on `stall_why` while `stall_flag` is 1.
- R10: In every `ST_RUN` stall cycle, exactly the counter of that cycle's reason in `stall_cnt` goes up by one.
- R11: In every `ST_RUN` cycle, bin N of `hist_cnt` goes up by one, where N is that cycle's admit count.
- R12: Credits returned in one cycle are seen by the admission checks only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | 3 | Requested dispatch width (0 = default) |
| cfg_prf_limit | input | 8 | Physical registers available for renaming (0 = unlimited) |
| cfg_lq_size | input | 8 | Load queue size (0 = default) |
| cfg_sq_size | input | 8 | Store queue size (0 = default) |
| in_valid | input | 4 | Valid bit for each head slot of the decoded queue, slot 0 oldest |
| in_uops | input | 4x3 | Micro-op count for each slot |
| in_dsts | input | 4x2 | Destination registers to rename for each slot |
| in_sched | input | 4x1 | Target scheduler ID for each slot |
| in_load | input | 4 | Slot is a load |
| in_store | input | 4 | Slot is a store |
| in_solo | input | 4 | Slot must be dispatched alone |
| ret_rob | input | 8 | Reorder-buffer entries freed this cycle |
| ret_regs | input | 8 | Physical registers freed by retirement this cycle |
| sched_ret | input | 2 | One slot freed in each flagged scheduler |
| lq_ret | input | 8 | Load-queue slots freed this cycle |
| sq_ret | input | 8 | Store-queue slots freed this cycle |
| ready | output | 1 | Controller is in `ST_RUN` |
| admit_cnt | output | 3 | Number of head slots admitted this cycle |
| stall_flag | output | 1 | This cycle is a stall cycle |
| stall_why | output | 3 | Stall reason code |
| stall_cnt | output | 6x16 | Stall-cycle counters, indexed by reason code |
| hist_cnt | output | 5x16 | Cycles with exactly N admitted, indexed by N |

## Verification
The main function is tried with uniform groups of plain instructions at several width settings. These separate the default, clamped and explicit widths, and show that width-limited groups raise no stall. Next come groups that run out of one resource at a time: reorder entries through large micro-op counts, registers under a small limit, then one scheduler, the load queue and the store queue. Each pattern shows that its own reason code is chosen and that credits return one cycle late. Overlapping shortages check the reason priority. Solo instructions placed in different slots separate a group cut short from a clean single admit, and counter deltas taken over these runs confirm the stall counters and the histogram.

// File: rtl/dac_pkg.sv
package dac_pkg;

    typedef enum logic [2:0] {
        WHY_REG   = 3'd0,
        WHY_ROB   = 3'd1,
        WHY_SCHED = 3'd2,
        WHY_LQ    = 3'd3,
        WHY_SQ    = 3'd4,
        WHY_GROUP = 3'd5
    } why_e;

    localparam int NUM_WHY = 6;

    typedef enum logic [0:0] {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } st_e;

endpackage

// File: rtl/dac_credit.sv
module dac_credit #(
    parameter int CRW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [CRW-1:0] cap,
    input  logic [CRW-1:0] take,
    input  logic [CRW-1:0] give,
    output logic [CRW-1:0] free
);

    // Consumption and returns both land at the edge, so returns are
    // visible to the admission logic one cycle after they arrive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free <= '0;
        end else if (load) begin
            free <= cap;
        end else begin
            free <= free - take + give;
        end
    end

endmodule

// File: rtl/dac_select.sv
module dac_select
    import dac_pkg::*;
#(
    parameter int WIDTH_MAX = 4,
    parameter int NUM_SCHED = 2,
    parameter int CRW       = 8,
    parameter int UW        = 3,
    parameter int DW        = 2,
    parameter int SW        = 1,
    parameter int WW        = 3
) (
    input  logic                               enable,
    input  logic [WW-1:0]                      eff_width,
    input  logic                               prf_unlim,
    input  logic [CRW-1:0]                     rob_free,
    input  logic [CRW-1:0]                     prf_free,
    input  logic [NUM_SCHED-1:0][CRW-1:0]      sched_free,
    input  logic [CRW-1:0]                     lq_free,
    input  logic [CRW-1:0]                     sq_free,
    input  logic [WIDTH_MAX-1:0]               in_valid,
    input  logic [WIDTH_MAX-1:0][UW-1:0]       in_uops,
    input  logic [WIDTH_MAX-1:0][DW-1:0]       in_dsts,
    input  logic [WIDTH_MAX-1:0][SW-1:0]       in_sched,
    input  logic [WIDTH_MAX-1:0]               in_load,
    input  logic [WIDTH_MAX-1:0]               in_store,
    input  logic [WIDTH_MAX-1:0]               in_solo,
    output logic [WW-1:0]                      admit_n,
    output logic [CRW-1:0]                     take_rob,
    output logic [CRW-1:0]                     take_prf,
    output logic [NUM_SCHED-1:0][CRW-1:0]      take_sched,
    output logic [CRW-1:0]                     take_lq,
    output logic [CRW-1:0]                     take_sq,
    output logic                               stall,
    output why_e                               why
);

    logic                          going;
    logic                          closed;
    logic                          blocked;
    logic                          sched_ok;
    why_e                          cause;
    logic [CRW-1:0]                rob_r;
    logic [CRW-1:0]                prf_r;
    logic [CRW-1:0]                lq_r;
    logic [CRW-1:0]                sq_r;
    logic [NUM_SCHED-1:0][CRW-1:0] sch_r;

    // In-order walk over the head slots with running credit balances.
    always_comb begin
        admit_n    = '0;
        take_rob   = '0;
        take_prf   = '0;
        take_sched = '0;
        take_lq    = '0;
        take_sq    = '0;
        stall      = 1'b0;
        why        = WHY_REG;
        going      = enable;
        closed     = 1'b0;
        blocked    = 1'b0;
        sched_ok   = 1'b0;
        cause      = WHY_REG;
        rob_r      = rob_free;
        prf_r      = prf_free;
        lq_r       = lq_free;
        sq_r       = sq_free;
        sch_r      = sched_free;
        for (int k = 0; k < WIDTH_MAX; k++) begin
            if (going) begin
                if (!in_valid[k] || (WW'(k) >= eff_width)) begin
                    going = 1'b0;
                end else begin
                    sched_ok = 1'b0;
                    for (int s = 0; s < NUM_SCHED; s++) begin
                        if (in_sched[k] == SW'(s) && sch_r[s] != '0) begin
                            sched_ok = 1'b1;
                        end
                    end
                    blocked = 1'b1;
                    if (!prf_unlim && (CRW'(in_dsts[k]) > prf_r)) begin
                        cause = WHY_REG;
                    end else if (CRW'(in_uops[k]) > rob_r) begin
                        cause = WHY_ROB;
                    end else if (!sched_ok) begin
                        cause = WHY_SCHED;
                    end else if (in_load[k] && lq_r == '0) begin
                        cause = WHY_LQ;
                    end else if (in_store[k] && sq_r == '0) begin
                        cause = WHY_SQ;
                    end else if (closed || (in_solo[k] && k != 0)) begin
                        cause = WHY_GROUP;
                    end else begin
                        blocked = 1'b0;
                    end

                    if (blocked) begin
                        going = 1'b0;
                        stall = 1'b1;
                        why   = cause;
                    end else begin
                        admit_n  = admit_n + 1'b1;
                        rob_r    = rob_r - CRW'(in_uops[k]);
                        take_rob = take_rob + CRW'(in_uops[k]);
                        if (!prf_unlim) begin
                            prf_r    = prf_r - CRW'(in_dsts[k]);
                            take_prf = take_prf + CRW'(in_dsts[k]);
                        end
                        for (int s = 0; s < NUM_SCHED; s++) begin
                            if (in_sched[k] == SW'(s)) begin
                                sch_r[s]      = sch_r[s] - 1'b1;
                                take_sched[s] = take_sched[s] + 1'b1;
                            end
                        end
                        if (in_load[k]) begin
                            lq_r    = lq_r - 1'b1;
                            take_lq = take_lq + 1'b1;
                        end
                        if (in_store[k]) begin
                            sq_r    = sq_r - 1'b1;
                            take_sq = take_sq + 1'b1;
                        end
                        if (in_solo[k]) begin
                            closed = 1'b1;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dac_stats.sv
module dac_stats #(
    parameter int WIDTH_MAX = 4,
    parameter int WW        = 3,
    parameter int CTR_W     = 16,
    parameter int NWHY      = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              count_en,
    input  logic [WW-1:0]                     admit_n,
    input  logic                              stall,
    input  logic [2:0]                        why,
    output logic [NWHY-1:0][CTR_W-1:0]        stall_cnt,
    output logic [WIDTH_MAX:0][CTR_W-1:0]     hist_cnt
);

    for (genvar b = 0; b <= WIDTH_MAX; b++) begin : g_bin
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hist_cnt[b] <= '0;
            end else if (count_en && admit_n == WW'(b)) begin
                hist_cnt[b] <= hist_cnt[b] + 1'b1;
            end
        end
    end

    for (genvar r = 0; r < NWHY; r++) begin : g_why
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stall_cnt[r] <= '0;
            end else if (count_en && stall && why == 3'(r)) begin
                stall_cnt[r] <= stall_cnt[r] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dac_dispatch_ctrl.sv
module dac_dispatch_ctrl
    import dac_pkg::*;
#(
    parameter int WIDTH_MAX   = 4,
    parameter int WIDTH_DEF   = 2,
    parameter int ROB_DEPTH   = 8,
    parameter int NUM_SCHED   = 2,
    parameter int SCHED_DEPTH = 4,
    parameter int LQ_DEFAULT  = 4,
    parameter int SQ_DEFAULT  = 4,
    parameter int CRW         = 8,
    parameter int UW          = 3,
    parameter int DW          = 2,
    parameter int CTR_W       = 16,
    localparam int WW         = $clog2(WIDTH_MAX + 1),
    localparam int SW         = (NUM_SCHED > 1) ? $clog2(NUM_SCHED) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [WW-1:0]                     cfg_width,
    input  logic [CRW-1:0]                    cfg_prf_limit,
    input  logic [CRW-1:0]                    cfg_lq_size,
    input  logic [CRW-1:0]                    cfg_sq_size,
    input  logic [WIDTH_MAX-1:0]              in_valid,
    input  logic [WIDTH_MAX-1:0][UW-1:0]      in_uops,
    input  logic [WIDTH_MAX-1:0][DW-1:0]      in_dsts,
    input  logic [WIDTH_MAX-1:0][SW-1:0]      in_sched,
    input  logic [WIDTH_MAX-1:0]              in_load,
    input  logic [WIDTH_MAX-1:0]              in_store,
    input  logic [WIDTH_MAX-1:0]              in_solo,
    input  logic [CRW-1:0]                    ret_rob,
    input  logic [CRW-1:0]                    ret_regs,
    input  logic [NUM_SCHED-1:0]              sched_ret,
    input  logic [CRW-1:0]                    lq_ret,
    input  logic [CRW-1:0]                    sq_ret,
    output logic                              ready,
    output logic [WW-1:0]                     admit_cnt,
    output logic                              stall_flag,
    output logic [2:0]                        stall_why,
    output logic [NUM_WHY-1:0][CTR_W-1:0]     stall_cnt,
    output logic [WIDTH_MAX:0][CTR_W-1:0]     hist_cnt
);

    st_e                           state_q;
    st_e                           state_d;
    logic                          load_en;
    logic                          run_en;
    logic [WW-1:0]                 eff_w;
    logic [WW-1:0]                 width_q;
    logic                          unlim_q;
    logic [CRW-1:0]                lq_cap;
    logic [CRW-1:0]                sq_cap;
    logic [CRW-1:0]                rob_free;
    logic [CRW-1:0]                prf_free;
    logic [CRW-1:0]                lq_free;
    logic [CRW-1:0]                sq_free;
    logic [NUM_SCHED-1:0][CRW-1:0] sched_free;
    logic [CRW-1:0]                take_rob;
    logic [CRW-1:0]                take_prf;
    logic [CRW-1:0]                take_lq;
    logic [CRW-1:0]                take_sq;
    logic [NUM_SCHED-1:0][CRW-1:0] take_sched;
    logic [CRW-1:0]                prf_give;
    why_e                          why;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and state-decoded controls.
    always_comb begin
        state_d = state_q;
        load_en = 1'b0;
        run_en  = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                load_en = 1'b1;
                state_d = ST_RUN;     // LOAD_DONE
            end
            ST_RUN: begin
                run_en  = 1'b1;
                state_d = ST_RUN;     // RUN_HOLD
            end
        endcase
    end

    assign ready = run_en;

    // Configuration resolution, sampled while loading.
    always_comb begin
        if (cfg_width == '0) begin
            eff_w = WW'(WIDTH_DEF);
        end else if (cfg_width > WW'(WIDTH_MAX)) begin
            eff_w = WW'(WIDTH_MAX);
        end else begin
            eff_w = cfg_width;
        end
    end

    assign lq_cap   = (cfg_lq_size == '0) ? CRW'(LQ_DEFAULT) : cfg_lq_size;
    assign sq_cap   = (cfg_sq_size == '0) ? CRW'(SQ_DEFAULT) : cfg_sq_size;
    assign prf_give = unlim_q ? '0 : ret_regs;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q <= WW'(WIDTH_DEF);
            unlim_q <= 1'b0;
        end else if (load_en) begin
            width_q <= eff_w;
            unlim_q <= (cfg_prf_limit == '0);
        end
    end

    // Credit pools.
    dac_credit #(.CRW(CRW)) u_rob (
        .clk(clk), .rst_n(rst_n), .load(load_en), .cap(CRW'(ROB_DEPTH)),
        .take(take_rob), .give(ret_rob), .free(rob_free)
    );

    dac_credit #(.CRW(CRW)) u_prf (
        .clk(clk), .rst_n(rst_n), .load(load_en), .cap(cfg_prf_limit),
        .take(take_prf), .give(prf_give), .free(prf_free)
    );

    dac_credit #(.CRW(CRW)) u_lq (
        .clk(clk), .rst_n(rst_n), .load(load_en), .cap(lq_cap),
        .take(take_lq), .give(lq_ret), .free(lq_free)
    );

    dac_credit #(.CRW(CRW)) u_sq (
        .clk(clk), .rst_n(rst_n), .load(load_en), .cap(sq_cap),
        .take(take_sq), .give(sq_ret), .free(sq_free)
    );

    for (genvar s = 0; s < NUM_SCHED; s++) begin : g_sched
        dac_credit #(.CRW(CRW)) u_slot (
            .clk(clk), .rst_n(rst_n), .load(load_en), .cap(CRW'(SCHED_DEPTH)),
            .take(take_sched[s]), .give(CRW'(sched_ret[s])), .free(sched_free[s])
        );
    end

    // Group formation.
    dac_select #(
        .WIDTH_MAX(WIDTH_MAX), .NUM_SCHED(NUM_SCHED), .CRW(CRW),
        .UW(UW), .DW(DW), .SW(SW), .WW(WW)
    ) u_sel (
        .enable(run_en), .eff_width(width_q), .prf_unlim(unlim_q),
        .rob_free(rob_free), .prf_free(prf_free), .sched_free(sched_free),
        .lq_free(lq_free), .sq_free(sq_free),
        .in_valid(in_valid), .in_uops(in_uops), .in_dsts(in_dsts),
        .in_sched(in_sched), .in_load(in_load), .in_store(in_store),
        .in_solo(in_solo),
        .admit_n(admit_cnt), .take_rob(take_rob), .take_prf(take_prf),
        .take_sched(take_sched), .take_lq(take_lq), .take_sq(take_sq),
        .stall(stall_flag), .why(why)
    );

    assign stall_why = why;

    // Statistics.
    dac_stats #(
        .WIDTH_MAX(WIDTH_MAX), .WW(WW), .CTR_W(CTR_W), .NWHY(NUM_WHY)
    ) u_stats (
        .clk(clk), .rst_n(rst_n), .count_en(run_en), .admit_n(admit_cnt),
        .stall(stall_flag), .why(stall_why),
        .stall_cnt(stall_cnt), .hist_cnt(hist_cnt)
    );

endmodule

// File: rtl/dac_dispatch_chk.sv
module dac_dispatch_chk #(
    parameter int WIDTH_MAX = 4,
    parameter int ROB_DEPTH = 8,
    parameter int CRW       = 8,
    parameter int CTR_W     = 16,
    parameter int WW        = 3,
    parameter int NWHY      = 6
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          ready,
    input logic [WW-1:0]                 admit_cnt,
    input logic                          stall_flag,
    input logic [2:0]                    stall_why,
    input logic [NWHY-1:0][CTR_W-1:0]    stall_cnt,
    input logic [WIDTH_MAX:0][CTR_W-1:0] hist_cnt,
    input logic [WIDTH_MAX-1:0]          in_valid,
    input logic [WIDTH_MAX-1:0]          in_solo,
    input logic [WW-1:0]                 width_q,
    input logic [CRW-1:0]                rob_free
);

    AST_LOAD_NO_ADMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (admit_cnt == '0 && !stall_flag));                       // R1

    AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        admit_cnt <= width_q);                                              // R3

    AST_ROB_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> rob_free <= CRW'(ROB_DEPTH));                             // R4

    AST_SOLO_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[0] && in_solo[0] && admit_cnt != '0) |-> admit_cnt == 1); // R8

    AST_REASON_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        stall_flag |-> stall_why < 3'(NWHY));                               // R9

    AST_STALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && stall_flag) |=>
        stall_cnt[$past(stall_why)] == CTR_W'($past(stall_cnt[stall_why]) + 1'b1)); // R10

    AST_HIST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=>
        hist_cnt[$past(admit_cnt)] == CTR_W'($past(hist_cnt[admit_cnt]) + 1'b1));   // R11

endmodule

bind dac_dispatch_ctrl dac_dispatch_chk #(
    .WIDTH_MAX(WIDTH_MAX), .ROB_DEPTH(ROB_DEPTH), .CRW(CRW),
    .CTR_W(CTR_W), .WW(WW), .NWHY(6)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .admit_cnt(admit_cnt),
    .stall_flag(stall_flag), .stall_why(stall_why), .stall_cnt(stall_cnt),
    .hist_cnt(hist_cnt), .in_valid(in_valid), .in_solo(in_solo),
    .width_q(width_q), .rob_free(rob_free)
);

// File: tb/tb_dac_dispatch_ctrl.sv
`timescale 1ns/100ps
module tb_dac_dispatch_ctrl;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       cfg_width = '0;
    logic [7:0]       cfg_prf_limit = '0;
    logic [7:0]       cfg_lq_size = '0;
    logic [7:0]       cfg_sq_size = '0;
    logic [3:0]       in_valid = '0;
    logic [3:0][2:0]  in_uops = '0;
    logic [3:0][1:0]  in_dsts = '0;
    logic [3:0][0:0]  in_sched = '0;
    logic [3:0]       in_load = '0;
    logic [3:0]       in_store = '0;
    logic [3:0]       in_solo = '0;
    logic [7:0]       ret_rob = '0;
    logic [7:0]       ret_regs = '0;
    logic [1:0]       sched_ret = '0;
    logic [7:0]       lq_ret = '0;
    logic [7:0]       sq_ret = '0;
    logic             ready;
    logic [2:0]       admit_cnt;
    logic             stall_flag;
    logic [2:0]       stall_why;
    logic [5:0][15:0] stall_cnt;
    logic [4:0][15:0] hist_cnt;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    dac_dispatch_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width),
        .cfg_prf_limit(cfg_prf_limit), .cfg_lq_size(cfg_lq_size),
        .cfg_sq_size(cfg_sq_size), .in_valid(in_valid), .in_uops(in_uops),
        .in_dsts(in_dsts), .in_sched(in_sched), .in_load(in_load),
        .in_store(in_store), .in_solo(in_solo), .ret_rob(ret_rob),
        .ret_regs(ret_regs), .sched_ret(sched_ret), .lq_ret(lq_ret),
        .sq_ret(sq_ret), .ready(ready), .admit_cnt(admit_cnt),
        .stall_flag(stall_flag), .stall_why(stall_why),
        .stall_cnt(stall_cnt), .hist_cnt(hist_cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance to 0.5 ns after the next rising edge.
    task automatic step();
        @(posedge clk);
        #0.5;
    endtask

    // Settle combinational outputs before sampling.
    task automatic settle();
        #0.5;
    endtask

    // smode: 0 all scheduler 0, 1 all scheduler 1, 2 alternating by slot.
    task automatic fill(input logic [3:0] m, input int u, input int d,
                        input int smode, input bit ld, input bit st);
        for (int k = 0; k < 4; k++) begin
            in_valid[k] = m[k];
            in_uops[k]  = 3'(u);
            in_dsts[k]  = 2'(d);
            in_sched[k] = (smode == 2) ? 1'(k % 2) : 1'(smode);
            in_load[k]  = ld;
            in_store[k] = st;
            in_solo[k]  = 1'b0;
        end
    endtask

    task automatic do_reset(input int w, input int prf, input int lq, input int sq);
        @(posedge clk);
        #0.5;
        rst_n = 1'b0;
        fill(4'h0, 0, 0, 0, 1'b0, 1'b0);
        ret_rob = '0; ret_regs = '0; sched_ret = '0; lq_ret = '0; sq_ret = '0;
        cfg_width = 3'(w);
        cfg_prf_limit = 8'(prf);
        cfg_lq_size = 8'(lq);
        cfg_sq_size = 8'(sq);
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(4, 0, 0, 0);
        fill(4'hF, 1, 0, 2, 1'b0, 1'b0);
        settle();
        chk("R1 ready low in load", int'(ready), 0);
        chk("R1 no admit in load", int'(admit_cnt), 0);
        chk("R1 no stall in load", int'(stall_flag), 0);
        for (int k = 0; k < 6; k++) chk("R1 stall counter zero", int'(stall_cnt[k]), 0);
        for (int k = 0; k < 5; k++) chk("R1 histogram zero", int'(hist_cnt[k]), 0);
        step();
        settle();
        chk("R1 ready high in run", int'(ready), 1);
        chk("R2 full width group", int'(admit_cnt), 4);
    endtask

    task automatic t_width();
        do_reset(0, 0, 0, 0);
        step();
        fill(4'hF, 1, 0, 2, 1'b0, 1'b0);
        settle();
        chk("R3 zero width selects default 2", int'(admit_cnt), 2);
        chk("R2 width limit is no stall", int'(stall_flag), 0);
        do_reset(3, 0, 0, 0);
        step();
        fill(4'hF, 1, 0, 2, 1'b0, 1'b0);
        settle();
        chk("R3 width 3", int'(admit_cnt), 3);
        do_reset(7, 0, 0, 0);
        step();
        fill(4'hF, 1, 0, 2, 1'b0, 1'b0);
        settle();
        chk("R3 width 7 clamped to 4", int'(admit_cnt), 4);
    endtask

    task automatic t_order();
        do_reset(4, 0, 0, 0);
        step();
        fill(4'b1011, 1, 0, 2, 1'b0, 1'b0);
        settle();
        chk("R2 invalid slot ends group", int'(admit_cnt), 2);
        chk("R2 invalid slot is no stall", int'(stall_flag), 0);
        step();
        fill(4'b0000, 1, 0, 2, 1'b0, 1'b0);
        settle();
        chk("R2 empty queue admits none", int'(admit_cnt), 0);
        chk("R2 empty queue is no stall", int'(stall_flag), 0);
    endtask

    task automatic t_rob();
        int s_rob;
        int h0;
        int h2;
        do_reset(4, 0, 0, 0);
        step();
        fill(4'hF, 3, 0, 0, 1'b0, 1'b0);
        settle();
        s_rob = int'(stall_cnt[1]);
        h0 = int'(hist_cnt[0]);
        h2 = int'(hist_cnt[2]);
        chk("R4 three-uop ops fit twice in 8", int'(admit_cnt), 2);
        chk("R4 stall flagged", int'(stall_flag), 1);
        chk("R9 reason code 1 for rob", int'(stall_why), 1);
        step();
        settle();
        chk("R4 two entries left admit none", int'(admit_cnt), 0);
        step();
        ret_rob = 8'd6;
        settle();
        chk("R12 return not seen same cycle", int'(admit_cnt), 0);
        step();
        ret_rob = '0;
        settle();
        chk("R12 return seen next cycle", int'(admit_cnt), 2);
        chk("R9 reason still rob", int'(stall_why), 1);
        step();
        fill(4'h0, 0, 0, 0, 1'b0, 1'b0);
        settle();
        chk("R10 rob stall counter +4", int'(stall_cnt[1]) - s_rob, 4);
        chk("R11 bin0 +2", int'(hist_cnt[0]) - h0, 2);
        chk("R11 bin2 +2", int'(hist_cnt[2]) - h2, 2);
    endtask

    task automatic t_reg();
        do_reset(4, 3, 0, 0);
        step();
        fill(4'hF, 1, 2, 2, 1'b0, 1'b0);
        settle();
        chk("R5 three regs fit one two-dest op", int'(admit_cnt), 1);
        chk("R9 reason code 0 for regs", int'(stall_why), 0);
        step();
        ret_regs = 8'd2;
        settle();
        chk("R5 one reg left admits none", int'(admit_cnt), 0);
        step();
        ret_regs = '0;
        settle();
        chk("R5 retire return refills regs", int'(admit_cnt), 1);
        do_reset(4, 0, 0, 0);
        step();
        fill(4'hF, 1, 3, 2, 1'b0, 1'b0);
        settle();
        chk("R5 zero limit is unlimited", int'(admit_cnt), 4);
        chk("R5 unlimited no stall", int'(stall_flag), 0);
    endtask

    task automatic t_sched_lq();
        do_reset(4, 0, 2, 0);
        step();
        fill(4'hF, 1, 0, 0, 1'b1, 1'b0);
        settle();
        chk("R7 load queue of 2", int'(admit_cnt), 2);
        chk("R9 reason code 3 for load queue", int'(stall_why), 3);
        step();
        fill(4'hF, 1, 0, 0, 1'b0, 1'b0);
        settle();
        chk("R6 scheduler 0 two slots left", int'(admit_cnt), 2);
        chk("R9 reason code 2 for scheduler", int'(stall_why), 2);
        step();
        fill(4'hF, 1, 0, 0, 1'b1, 1'b0);
        settle();
        chk("R9 scheduler outranks load queue", int'(stall_why), 2);
        step();
        sched_ret = 2'b01;
        settle();
        chk("R12 issue return not seen same cycle", int'(stall_why), 2);
        step();
        sched_ret = 2'b00;
        settle();
        chk("R9 load queue after scheduler freed", int'(stall_why), 3);
        chk("R6 load blocked admits none", int'(admit_cnt), 0);
        fill(4'hF, 1, 0, 1, 1'b0, 1'b0);
        settle();
        chk("R6 scheduler 1 independent", int'(admit_cnt), 4);
    endtask

    task automatic t_sq();
        do_reset(4, 0, 0, 0);
        step();
        fill(4'hF, 1, 0, 2, 1'b0, 1'b1);
        settle();
        chk("R7 zero store size gives 4", int'(admit_cnt), 4);
        step();
        settle();
        chk("R7 store queue exhausted", int'(admit_cnt), 0);
        chk("R9 reason code 4 for store queue", int'(stall_why), 4);
    endtask

    task automatic t_group();
        do_reset(4, 0, 0, 0);
        step();
        fill(4'hF, 1, 0, 2, 1'b0, 1'b0);
        in_solo[1] = 1'b1;
        settle();
        chk("R8 solo in slot 1 ends group", int'(admit_cnt), 1);
        chk("R9 reason code 5 for group", int'(stall_why), 5);
        step();
        fill(4'hF, 1, 0, 2, 1'b0, 1'b0);
        in_solo[0] = 1'b1;
        settle();
        chk("R8 solo in slot 0 goes alone", int'(admit_cnt), 1);
        chk("R8 follower is group stall", int'(stall_why), 5);
        step();
        fill(4'b0001, 1, 0, 2, 1'b0, 1'b0);
        in_solo[0] = 1'b1;
        settle();
        chk("R8 lone solo admitted", int'(admit_cnt), 1);
        chk("R8 lone solo no stall", int'(stall_flag), 0);
    endtask

    initial begin
        #(200000 * 4);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_width();
        t_order();
        t_rob();
        t_reg();
        t_sched_lq();
        t_sq();
        t_group();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule